// File: doc/BRIEF.md
# Three-Stage Time-Space-Time Slot Switch

This block connects any time slot of any incoming highway to any time slot of any outgoing highway. It is built as a ring of three stages. A bank of input time switches moves samples into an internal slot. A time-multiplexed crossbar moves each internal slot between highways. A bank of output time switches moves each sample from its internal slot into the slot it must leave on. Each highway carries one parallel sample per clock, and one clock is one slot. A single free-running slot counter paces every stage.

A host builds one direction of a call with three writes, all at the same internal slot index `k`:
- The input switch of the source highway is told which incoming slot to fetch.
- The crossbar column of the destination highway is told which internal row to take.
- The output switch of the destination highway is told which outgoing slot to fill.

A two-way call uses two internal slots, one for each direction. The host releases a path by erasing the same three entries, and the internal slot can then be used again. Finding a free internal slot is left to the host.

Top module: `tst_network`

## Requirements
- R1: After reset `slot_idx` is 0 in the first cycle. It then counts up by one each clock and goes back to 0 after slot 31. Incoming samples on `rx_data` belong to the slot shown on `slot_idx` in the same cycle.
- R2: While reset is held, `tx_data`, `tx_slot` and `slot_idx` are all zero, and all stored samples and routing entries are cleared.
- R3: Each input switch writes the sample of its highway, taken in slot `s`, into its own location `s`, whatever the routing entries hold.
- R4: In internal slot `k`, an input switch with a valid entry holding source `src` sends out the content of location `src` as it stood before that cycle. For `src < k` this is the sample from the same frame; otherwise it is the sample from the previous frame. An invalid entry sends all zeros.
- R5: In internal slot `k`, crossbar column `c` with a valid entry holding row `r` (in bits [1:0] of the host value) passes the internal sample of highway `r` to output switch `c`. Several columns may take the same row. An invalid entry passes all zeros.
- R6: In internal slot `k`, an output switch with a valid entry holding destination `dst` stores the crossbar sample at location `dst`. An invalid entry stores nothing.
- R7: Output switches read location `j` in slot `j` and clear it in the same cycle. A write in that same cycle takes priority over the clear. The value read appears on `tx_data` one clock later, with `tx_slot` equal to `j`. A location that was not written since its last read gives zero.
- R8: The path from slot 4 of input highway 0 through internal slot 10 to slot 6 of output highway 3 delivers the sample on slot 6 of output highway 3 in the frame after the one in which it arrived.
- R9: Host write: `cfg_en` is high for one clock. `cfg_stage` selects the stage: 0 = input switches, 1 = crossbar, 2 = output switches. `cfg_hwy` selects the switch or column, `cfg_islot` selects the internal slot, and `cfg_val` is the source slot, row or destination slot. With `cfg_erase`=0 the entry is made valid; with `cfg_erase`=1 it is made invalid. The entry takes effect from the next clock.
- R10: A host write with `cfg_stage` = 3 changes no entry.
- R11: The two directions of a call, on two different internal slots, are carried at the same time and do not disturb each other.
- R12: After a path is erased, its destination slot gives zero. The freed internal slot can then carry a different path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | N_HWY*SW | Incoming samples; highway h in bits [h*SW +: SW] |
| slot_idx | output | SLOT_W | Slot to which the current `rx_data` belongs |
| tx_data | output | N_HWY*SW | Outgoing samples; highway h in bits [h*SW +: SW] |
| tx_slot | output | SLOT_W | Slot to which the current `tx_data` belongs |
| cfg_en | input | 1 | Host write strobe |
| cfg_stage | input | 2 | Stage select (0 input, 1 crossbar, 2 output, 3 none) |
| cfg_hwy | input | HWY_W | Switch or column number |
| cfg_islot | input | SLOT_W | Internal slot (entry location) |
| cfg_val | input | SLOT_W | Source slot, row, or destination slot |
| cfg_erase | input | 1 | 1 makes the entry invalid |

## Verification
The assertions take for granted that reset is asserted before the first clock edge. They also assume that the only way samples enter the block is through `rx_data`, so an all-zero internal highway can only produce an all-zero crossbar output. The end-to-end data compare additionally assumes that no two valid entries of one output switch name the same destination slot, and that routing is not changed inside the window a sample is in flight. The stimulus keeps every destination unique per output highway. The bench also compares only the slots whose whole path was set up more than 40 cycles after the last host write that changed an entry. Writes with stage code 3 do not open such a pause, so the compare keeps running through them.

// File: rtl/tst_pkg.sv
package tst_pkg;

  typedef enum logic [1:0] {
    STG_IN    = 2'd0,
    STG_SPACE = 2'd1,
    STG_OUT   = 2'd2,
    STG_NONE  = 2'd3
  } stage_e;

  // Slot following cur in a frame of n_slot slots.
  function automatic int unsigned next_slot(int unsigned cur, int unsigned n_slot);
    return (cur + 1 >= n_slot) ? 0 : cur + 1;
  endfunction

  // Entry contents written by the host: erase leaves a zero field.
  function automatic int unsigned entry_field(logic erase, int unsigned val);
    return erase ? 0 : val;
  endfunction

endpackage

// File: rtl/tst_slot_timer.sv
module tst_slot_timer
  import tst_pkg::*;
#(
  parameter int N_SLOT = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] tag1,
  output logic [SLOT_W-1:0] tag2
);

  // tag1/tag2 follow the slot through the crossbar and output stage registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      tag1 <= '0;
      tag2 <= '0;
    end else begin
      slot <= SLOT_W'(next_slot(32'(slot), N_SLOT));
      tag1 <= slot;
      tag2 <= tag1;
    end
  end

endmodule

// File: rtl/tst_in_switch.sv
module tst_in_switch
  import tst_pkg::*;
#(
  parameter int N_SLOT = 32,
  parameter int SLOT_W = 5,
  parameter int SW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [SW-1:0]     rx_sample,
  input  logic              cfg_we,
  input  logic              cfg_erase,
  input  logic [SLOT_W-1:0] cfg_loc,
  input  logic [SLOT_W-1:0] cfg_src,
  output logic [SW-1:0]     int_sample
);

  logic [SW-1:0]     speech  [N_SLOT];
  logic              ctl_v   [N_SLOT];
  logic [SLOT_W-1:0] ctl_src [N_SLOT];

  logic              rd_v;
  logic [SW-1:0]     rd_sample;

  // Sequential write, controlled read (R3, R4).
  assign rd_v      = ctl_v[cur_slot];
  assign rd_sample = speech[ctl_src[cur_slot]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOT; i++) begin
        speech[i]  <= '0;
        ctl_v[i]   <= 1'b0;
        ctl_src[i] <= '0;
      end
      int_sample <= '0;
    end else begin
      speech[cur_slot] <= rx_sample;
      if (cfg_we) begin
        ctl_v[cfg_loc]   <= ~cfg_erase;
        ctl_src[cfg_loc] <= SLOT_W'(entry_field(cfg_erase, 32'(cfg_src)));
      end
      int_sample <= rd_v ? rd_sample : '0;
    end
  end

endmodule

// File: rtl/tst_space_matrix.sv
module tst_space_matrix
  import tst_pkg::*;
#(
  parameter int N_HWY  = 4,
  parameter int N_SLOT = 32,
  parameter int SLOT_W = 5,
  parameter int HWY_W  = 2,
  parameter int SW     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOT_W-1:0]   int_slot,
  input  logic [N_HWY*SW-1:0] int_bus,
  input  logic                cfg_we,
  input  logic                cfg_erase,
  input  logic [HWY_W-1:0]    cfg_col,
  input  logic [SLOT_W-1:0]   cfg_loc,
  input  logic [HWY_W-1:0]    cfg_row,
  output logic [N_HWY*SW-1:0] sp_bus
);

  logic [SW-1:0] in_lane [N_HWY];

  for (genvar r = 0; r < N_HWY; r++) begin : g_lane
    assign in_lane[r] = int_bus[r*SW +: SW];
  end

  // One control column per outgoing highway (R5).
  for (genvar c = 0; c < N_HWY; c++) begin : g_col
    logic             col_v   [N_SLOT];
    logic [HWY_W-1:0] col_row [N_SLOT];
    logic             col_we;
    logic             hit;
    logic [HWY_W-1:0] sel;
    logic [SW-1:0]    col_q;

    assign col_we = cfg_we && (cfg_col == HWY_W'(c));
    assign hit    = col_v[int_slot];
    assign sel    = col_row[int_slot];
    assign sp_bus[c*SW +: SW] = col_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N_SLOT; i++) begin
          col_v[i]   <= 1'b0;
          col_row[i] <= '0;
        end
        col_q <= '0;
      end else begin
        if (col_we) begin
          col_v[cfg_loc]   <= ~cfg_erase;
          col_row[cfg_loc] <= HWY_W'(entry_field(cfg_erase, 32'(cfg_row)));
        end
        col_q <= hit ? in_lane[sel] : '0;
      end
    end
  end

endmodule

// File: rtl/tst_out_switch.sv
module tst_out_switch
  import tst_pkg::*;
#(
  parameter int N_SLOT = 32,
  parameter int SLOT_W = 5,
  parameter int SW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [SW-1:0]     sp_sample,
  input  logic              cfg_we,
  input  logic              cfg_erase,
  input  logic [SLOT_W-1:0] cfg_loc,
  input  logic [SLOT_W-1:0] cfg_dst,
  output logic [SW-1:0]     tx_sample,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_addr
);

  logic [SW-1:0]     speech  [N_SLOT];
  logic              ctl_v   [N_SLOT];
  logic [SLOT_W-1:0] ctl_dst [N_SLOT];

  // Controlled write, sequential read with clear (R6, R7).
  assign wr_en   = ctl_v[wr_slot];
  assign wr_addr = ctl_dst[wr_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOT; i++) begin
        speech[i]  <= '0;
        ctl_v[i]   <= 1'b0;
        ctl_dst[i] <= '0;
      end
      tx_sample <= '0;
    end else begin
      tx_sample        <= speech[cur_slot];
      speech[cur_slot] <= '0;
      if (wr_en) speech[wr_addr] <= sp_sample;  // later assignment wins over clear
      if (cfg_we) begin
        ctl_v[cfg_loc]   <= ~cfg_erase;
        ctl_dst[cfg_loc] <= SLOT_W'(entry_field(cfg_erase, 32'(cfg_dst)));
      end
    end
  end

endmodule

// File: rtl/tst_network.sv
module tst_network
  import tst_pkg::*;
#(
  parameter int N_HWY  = 4,
  parameter int N_SLOT = 32,
  parameter int SW     = 8,
  localparam int HWY_W  = $clog2(N_HWY),
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_HWY*SW-1:0] rx_data,
  output logic [SLOT_W-1:0]   slot_idx,
  output logic [N_HWY*SW-1:0] tx_data,
  output logic [SLOT_W-1:0]   tx_slot,
  input  logic                cfg_en,
  input  logic [1:0]          cfg_stage,
  input  logic [HWY_W-1:0]    cfg_hwy,
  input  logic [SLOT_W-1:0]   cfg_islot,
  input  logic [SLOT_W-1:0]   cfg_val,
  input  logic                cfg_erase
);

  stage_e              stg;
  logic [SLOT_W-1:0]   int_slot;
  logic [SLOT_W-1:0]   sp_slot;
  logic [N_HWY*SW-1:0] int_bus;
  logic [N_HWY*SW-1:0] sp_bus;
  logic [N_HWY-1:0]    out_wr_en;
  logic [N_HWY*SLOT_W-1:0] out_wr_addr;
  logic                sp_we;

  assign stg   = stage_e'(cfg_stage);
  assign sp_we = cfg_en && (stg == STG_SPACE);

  tst_slot_timer #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .slot (slot_idx),
    .tag1 (int_slot),
    .tag2 (sp_slot)
  );

  for (genvar h = 0; h < N_HWY; h++) begin : g_in
    logic in_we;
    assign in_we = cfg_en && (stg == STG_IN) && (cfg_hwy == HWY_W'(h));
    tst_in_switch #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .SW(SW)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_slot  (slot_idx),
      .rx_sample (rx_data[h*SW +: SW]),
      .cfg_we    (in_we),
      .cfg_erase (cfg_erase),
      .cfg_loc   (cfg_islot),
      .cfg_src   (cfg_val),
      .int_sample(int_bus[h*SW +: SW])
    );
  end

  tst_space_matrix #(
    .N_HWY(N_HWY), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .HWY_W(HWY_W), .SW(SW)
  ) u_space (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_slot (int_slot),
    .int_bus  (int_bus),
    .cfg_we   (sp_we),
    .cfg_erase(cfg_erase),
    .cfg_col  (cfg_hwy),
    .cfg_loc  (cfg_islot),
    .cfg_row  (cfg_val[HWY_W-1:0]),
    .sp_bus   (sp_bus)
  );

  for (genvar h = 0; h < N_HWY; h++) begin : g_out
    logic out_we;
    assign out_we = cfg_en && (stg == STG_OUT) && (cfg_hwy == HWY_W'(h));
    tst_out_switch #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .SW(SW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_slot (slot_idx),
      .wr_slot  (sp_slot),
      .sp_sample(sp_bus[h*SW +: SW]),
      .cfg_we   (out_we),
      .cfg_erase(cfg_erase),
      .cfg_loc  (cfg_islot),
      .cfg_dst  (cfg_val),
      .tx_sample(tx_data[h*SW +: SW]),
      .wr_en    (out_wr_en[h]),
      .wr_addr  (out_wr_addr[h*SLOT_W +: SLOT_W])
    );
  end

  // tx_data is registered once after the read, so the slot label follows by one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_slot <= '0;
    else        tx_slot <= slot_idx;
  end

endmodule

// File: rtl/tst_network_chk.sv
module tst_network_chk #(
  parameter int N_HWY  = 4,
  parameter int N_SLOT = 32,
  parameter int SW     = 8,
  parameter int SLOT_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SLOT_W-1:0]   slot_idx,
  input logic [SLOT_W-1:0]   tx_slot,
  input logic [SLOT_W-1:0]   sp_slot,
  input logic [N_HWY*SW-1:0] int_bus,
  input logic [N_HWY*SW-1:0] sp_bus
);

  // R1: frame wrap
  a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == SLOT_W'(N_SLOT-1)) |=> (slot_idx == '0));

  // R1: step by one inside the frame
  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx != SLOT_W'(N_SLOT-1)) |=> (slot_idx == SLOT_W'($past(slot_idx) + 1'b1)));

  // R7: outgoing label trails the read slot by one clock
  a_r7_tx_slot_align: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot == $past(slot_idx));

  // R6: output stage writes with the internal slot of two clocks earlier
  a_r6_out_tag_align: assert property (@(posedge clk) disable iff (!rst_n)
    sp_slot == $past(slot_idx, 2));

  // R5: crossbar only forwards what the input stage sent; idle stays zero
  for (genvar c = 0; c < N_HWY; c++) begin : g_idle
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_bus[c*SW +: SW] != '0) |-> $past(int_bus != '0));
  end

endmodule

bind tst_network tst_network_chk #(
  .N_HWY(N_HWY), .N_SLOT(N_SLOT), .SW(SW), .SLOT_W(SLOT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slot_idx(slot_idx),
  .tx_slot (tx_slot),
  .sp_slot (sp_slot),
  .int_bus (int_bus),
  .sp_bus  (sp_bus)
);

// File: tb/tst_network_tb.sv
module tst_network_tb;
  localparam int NH  = 4;
  localparam int NS  = 32;
  localparam int SW  = 8;
  localparam int HWW = 2;
  localparam int SLW = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NH*SW-1:0]  rx_data;
  logic [SLW-1:0]    slot_idx;
  logic [NH*SW-1:0]  tx_data;
  logic [SLW-1:0]    tx_slot;
  logic              cfg_en;
  logic [1:0]        cfg_stage;
  logic [HWW-1:0]    cfg_hwy;
  logic [SLW-1:0]    cfg_islot;
  logic [SLW-1:0]    cfg_val;
  logic              cfg_erase;

  always #10 clk = ~clk;

  tst_network u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .slot_idx(slot_idx),
    .tx_data(tx_data), .tx_slot(tx_slot), .cfg_en(cfg_en), .cfg_stage(cfg_stage),
    .cfg_hwy(cfg_hwy), .cfg_islot(cfg_islot), .cfg_val(cfg_val), .cfg_erase(cfg_erase)
  );

  int    T = 0;
  int    n_checks = 0;
  int    n_errs = 0;
  int    last_cfg = -1000;
  bit    done = 1'b0;
  string cur_req = "R7";

  // Host's view of the routing, kept by the bench.
  bit m_in_v  [NH][NS];
  int m_in_src[NH][NS];
  bit m_sp_v  [NH][NS];
  int m_sp_row[NH][NS];
  bit m_out_v [NH][NS];
  int m_out_dst[NH][NS];

  function automatic int pat(int h, int t);
    return ((t * 7 + h * 61 + 3) % 255) + 1;
  endfunction

  // Latest cycle <= lim whose slot is s.
  function automatic int last_at(int lim, int s);
    return lim - (((lim - s) % NS + NS) % NS);
  endfunction

  // Expected sample on output highway o, slot j, read in cycle tj.
  function automatic int exp_tx(int o, int j, int tj);
    int k, tk, r, ts;
    k = -1;
    for (int q = 0; q < NS; q++)
      if (m_out_v[o][q] && m_out_dst[o][q] == j) k = q;
    if (k < 0) return 0;
    tk = last_at(tj - 3, k);
    if (tk < 0 || !m_sp_v[o][k]) return 0;
    r = m_sp_row[o][k];
    if (!m_in_v[r][k]) return 0;
    ts = last_at(tk - 1, m_in_src[r][k]);
    if (ts < 0) return 0;
    return pat(r, ts);
  endfunction

  task automatic check(string req, int act, int expv, string what);
    n_checks++;
    if (act != expv) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, T);
    end
  endtask

  always @(posedge clk) if (rst_n) T = T + 1;

  // Reference compare on every clock, then drive the samples for this cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1", int'(slot_idx), T % NS, "slot_idx");
      if (T >= 1) check("R7", int'(tx_slot), (T - 1) % NS, "tx_slot");
      if (T >= 4 && (T - 1) - last_cfg > 40)
        for (int o = 0; o < NH; o++)
          check(cur_req, int'(tx_data[o*SW +: SW]), exp_tx(o, (T - 1) % NS, T - 1), "tx_data");
    end
    for (int h = 0; h < NH; h++) rx_data[h*SW +: SW] = SW'(pat(h, T));
  end

  task automatic host_wr(int stage, int hwy, int islot, int val, bit erase);
    @(negedge clk);
    cfg_en = 1'b1; cfg_stage = 2'(stage); cfg_hwy = HWW'(hwy);
    cfg_islot = SLW'(islot); cfg_val = SLW'(val); cfg_erase = erase;
    if (stage != 3) last_cfg = T;  // R10: stage code 3 opens no pause in the compare
    case (stage)
      0: begin m_in_v[hwy][islot] = !erase; m_in_src[hwy][islot] = val; end
      1: begin m_sp_v[hwy][islot] = !erase; m_sp_row[hwy][islot] = val; end
      2: begin m_out_v[hwy][islot] = !erase; m_out_dst[hwy][islot] = val; end
      default: ;
    endcase
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic run_frames(int n);
    repeat (n * NS) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    int tj;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_stage = '0; cfg_hwy = '0;
    cfg_islot = '0; cfg_val = '0; cfg_erase = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: reset state
    check("R2", int'(tx_data), 0, "tx_data in reset");
    check("R2", int'(tx_slot), 0, "tx_slot in reset");
    check("R2", int'(slot_idx), 0, "slot_idx in reset");
    @(posedge clk);
    #5 rst_n = 1'b1;

    // R7: nothing routed, every slot idle
    cur_req = "R7";
    run_frames(2);

    // R9/R11: two-way call on internal slots 10 and 11
    host_wr(0, 0, 10, 4, 1'b0);
    host_wr(1, 3, 10, 0, 1'b0);
    host_wr(2, 3, 10, 6, 1'b0);
    host_wr(0, 3, 11, 6, 1'b0);
    host_wr(1, 0, 11, 3, 1'b0);
    host_wr(2, 0, 11, 4, 1'b0);
    cur_req = "R11";
    run_frames(4);

    // R8: slot 6 of output highway 3 carries slot 4 of input highway 0 from the frame before
    @(negedge clk);
    while (tx_slot != 5'd6) @(negedge clk);
    tj = T - 1;
    check("R8", int'(tx_data[3*SW +: SW]), pat(0, (tj / NS - 1) * NS + 4), "next-frame delivery");

    // R3/R4/R5/R6: source after internal slot, missing stages, shared row
    host_wr(0, 1, 3, 20, 1'b0);
    host_wr(1, 2, 3, 1, 1'b0);
    host_wr(2, 2, 3, 30, 1'b0);
    host_wr(0, 2, 5, 7, 1'b0);   // R5: no crossbar entry at slot 5
    host_wr(2, 1, 5, 9, 1'b0);
    host_wr(1, 0, 7, 1, 1'b0);   // R4: no input entry at slot 7
    host_wr(2, 0, 7, 15, 1'b0);
    host_wr(0, 0, 12, 1, 1'b0);
    host_wr(1, 1, 12, 0, 1'b0);
    host_wr(1, 2, 12, 0, 1'b0);
    host_wr(2, 1, 12, 2, 1'b0);
    host_wr(2, 2, 12, 3, 1'b0);
    cur_req = "R3/R4/R5/R6";
    run_frames(4);

    // R10: stage code 3 must leave slot 10 routing as it is
    cur_req = "R10";
    host_wr(3, 3, 10, 9, 1'b0);
    host_wr(3, 0, 10, 2, 1'b1);
    run_frames(3);

    // R12: release slot 10, then reuse it for another path
    host_wr(0, 0, 10, 0, 1'b1);
    host_wr(1, 3, 10, 0, 1'b1);
    host_wr(2, 3, 10, 0, 1'b1);
    cur_req = "R12";
    run_frames(3);
    host_wr(0, 2, 10, 0, 1'b0);
    host_wr(1, 1, 10, 2, 1'b0);
    host_wr(2, 1, 10, 31, 1'b0);
    run_frames(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule